// File: doc/BRIEF.md
# CLOCK Replacement Engine with Selectable Insertion

This block keeps the replacement state of a set-associative cache and chooses eviction victims with a CLOCK sweep instead of true LRU. Each set holds one recency ("use") bit per way and one rotating pointer (the hand). When a read misses, the engine walks the hand across the ways of the addressed set. It clears every recency bit it passes and stops at the first way whose bit is already clear. That way is reported as the victim.

When the victim is refilled, its recency bit is written according to one of four insertion modes. Normal mode always marks it. Rare mode marks it with a probability of roughly 1/32. Half mode marks it in alternating runs of 64 marked fills and 64 unmarked fills. Thread mode uses normal insertion for a thread flagged fragile and rare insertion for any other thread. Read hits mark the hit way. Writes never touch the state. Tags, data and the choice of mode belong to the surrounding cache.

The controller is a three-state machine:
- ST_IDLE accepts requests. A read hit stays in ST_IDLE. A read miss takes the transition "miss accepted" to ST_SWEEP.
- ST_SWEEP examines one way per cycle. While the examined bit is set it takes the "skip" transition back to ST_SWEEP. On a clear bit it takes "victim found" to ST_FILL.
- ST_FILL strobes the result, writes the fill bit and takes "fill written" back to ST_IDLE.

Top module: `clock_repl`

## Requirements
- R1: A synchronous reset clears every recency bit and every hand, and leaves `busy` and `victim_done` low. After reset, the first read miss to any set returns way 0 two cycles after it is sampled.
- R2: A read hit (`req_hit`=1, `req_write`=0) sampled while idle marks the recency bit of `req_way` in `req_set`. It raises neither `busy` nor `victim_done`.
- R3: A write request (`req_write`=1), hit or miss, changes no recency bit and no hand, and produces no `victim_done`.
- R4: A read miss sampled at edge t raises `busy` from t. The sweep examines the way under the hand once per cycle. A marked way is cleared and the hand advances by one, wrapping after the last way. `victim_done` is high for exactly one cycle, after edge t+1+k, where k is the number of marked ways passed. `victim_way` is valid in that cycle.
- R5: The hand stays on the victim. With `req_mode`=0 (normal), the fill marks the victim, so the next miss to that set skips it.
- R6: With `req_mode`=1 (rare), the fill marks the victim only when 5 bits of a free-running pseudo-random generator are all zero, which happens about once in 32 fills. Otherwise the victim is left unmarked.
- R7: With `req_mode`=2 (half), the fill marks the victim when a count of all fills since reset, taken modulo 128, is below 64. Otherwise the victim is left unmarked.
- R8: With `req_mode`=3 (thread), a fill with `req_fragile`=1 behaves as mode 0. A fill with `req_fragile`=0 behaves as mode 1.
- R9: Requests presented while `busy` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_set | input | SET_W (4) | Set index |
| req_way | input | WAY_W (4) | Hit way (used on hits) |
| req_hit | input | 1 | 1 = hit, 0 = miss |
| req_write | input | 1 | 1 = write access (ignored) |
| req_mode | input | 2 | Insertion mode for a miss: 0 normal, 1 rare, 2 half, 3 thread |
| req_fragile | input | 1 | Requesting thread is fragile (mode 3) |
| busy | output | 1 | Sweep or fill in progress |
| victim_done | output | 1 | One-cycle strobe: victim chosen |
| victim_way | output | WAY_W (4) | Chosen victim, valid with `victim_done` |

## Verification
Two functions can land in the same cycle: a new request arriving while a sweep is running, and the sweep writing the state. The bench provokes this by starting a miss on one set and, in the first sweep cycle, presenting a read hit to a different, untouched set. It judges the outcome by a later miss to that second set: the miss must still return way 0 after two cycles, which shows the hit left no mark. A reset asserted after many sets have been marked is judged the same way, by the victim and the latency of the next miss.

// File: rtl/clock_repl_pkg.sv
package clock_repl_pkg;

    typedef enum logic [1:0] {
        INS_NORMAL = 2'd0,
        INS_RARE   = 2'd1,
        INS_HALF   = 2'd2,
        INS_THREAD = 2'd3
    } ins_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SWEEP = 2'd1,
        ST_FILL  = 2'd2
    } repl_state_e;

endpackage

// File: rtl/rp_lfsr.sv
module rp_lfsr #(
    parameter int W         = 16,
    parameter int PICK_BITS = 5,
    parameter logic [W-1:0] TAPS = W'('hB400),
    parameter logic [W-1:0] SEED = W'('hACE1)
) (
    input  logic clk,
    input  logic rst,
    output logic rare_set
);
    logic [W-1:0] q;

    // Galois shift register, advances every cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= SEED;
        end else begin
            q <= (q >> 1) ^ (q[0] ? TAPS : '0);
        end
    end

    assign rare_set = (q[PICK_BITS-1:0] == '0);
endmodule

// File: rtl/rp_burst.sv
module rp_burst #(
    parameter int RUN = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic step,
    output logic phase_on
);
    localparam int PERIOD = 2 * RUN;
    localparam int CW     = $clog2(PERIOD);

    logic [CW-1:0] cnt;

    // counts fills modulo PERIOD
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (step) begin
            cnt <= (cnt == CW'(PERIOD - 1)) ? '0 : cnt + 1'b1;
        end
    end

    assign phase_on = (cnt < CW'(RUN));
endmodule

// File: rtl/rp_store.sv
module rp_store #(
    parameter int SETS = 16,
    parameter int WAYS = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [SET_W-1:0] rd_set,
    output logic [WAYS-1:0]  rd_use,
    output logic [WAY_W-1:0] rd_hand,
    input  logic [SET_W-1:0] wr_set,
    input  logic             wr_en,
    input  logic [WAY_W-1:0] wr_way,
    input  logic             wr_val,
    input  logic             adv_en
);
    logic [WAYS-1:0]  use_all  [SETS];
    logic [WAY_W-1:0] hand_all [SETS];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        logic [WAYS-1:0]  u;
        logic [WAY_W-1:0] h;
        logic             sel;

        assign sel = (wr_set == SET_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                u <= '0;
                h <= '0;
            end else if (sel) begin
                if (wr_en) begin
                    u[wr_way] <= wr_val;
                end
                if (adv_en) begin
                    h <= (h == WAY_W'(WAYS - 1)) ? '0 : h + 1'b1;
                end
            end
        end

        assign use_all[g]  = u;
        assign hand_all[g] = h;
    end

    assign rd_use  = use_all[rd_set];
    assign rd_hand = hand_all[rd_set];
endmodule

// File: rtl/clock_repl.sv
module clock_repl
    import clock_repl_pkg::*;
#(
    parameter int SETS      = 16,
    parameter int WAYS      = 16,
    parameter int RARE_BITS = 5,
    parameter int HALF_RUN  = 64,
    parameter int LFSR_W    = 16,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [SET_W-1:0] req_set,
    input  logic [WAY_W-1:0] req_way,
    input  logic             req_hit,
    input  logic             req_write,
    input  logic [1:0]       req_mode,
    input  logic             req_fragile,
    output logic             busy,
    output logic             victim_done,
    output logic [WAY_W-1:0] victim_way
);
    repl_state_e state_q, state_d;

    logic [SET_W-1:0] cur_set_q;
    ins_mode_e        cur_mode_q;
    logic             cur_frag_q;

    logic [WAYS-1:0]  rd_use;
    logic [WAY_W-1:0] rd_hand;
    logic [SET_W-1:0] wr_set;
    logic             wr_en;
    logic [WAY_W-1:0] wr_way;
    logic             wr_val;
    logic             adv_en;
    logic             fill_step;
    logic             rare_set;
    logic             phase_on;
    logic             fill_val;
    logic             take_hit;
    logic             take_miss;

    assign take_hit  = req_valid && !req_write && req_hit;
    assign take_miss = req_valid && !req_write && !req_hit;

    rp_store #(.SETS(SETS), .WAYS(WAYS)) u_store (
        .clk     (clk),
        .rst     (rst),
        .rd_set  (cur_set_q),
        .rd_use  (rd_use),
        .rd_hand (rd_hand),
        .wr_set  (wr_set),
        .wr_en   (wr_en),
        .wr_way  (wr_way),
        .wr_val  (wr_val),
        .adv_en  (adv_en)
    );

    rp_lfsr #(.W(LFSR_W), .PICK_BITS(RARE_BITS)) u_rng (
        .clk      (clk),
        .rst      (rst),
        .rare_set (rare_set)
    );

    rp_burst #(.RUN(HALF_RUN)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .step     (fill_step),
        .phase_on (phase_on)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // miss context captured when a sweep starts
    always_ff @(posedge clk) begin
        if (rst) begin
            cur_set_q  <= '0;
            cur_mode_q <= INS_NORMAL;
            cur_frag_q <= 1'b0;
        end else if (state_q == ST_IDLE && take_miss) begin
            cur_set_q  <= req_set;
            cur_mode_q <= ins_mode_e'(req_mode);
            cur_frag_q <= req_fragile;
        end
    end

    // fill value selected by insertion mode
    always_comb begin
        unique case (cur_mode_q)
            INS_NORMAL: fill_val = 1'b1;
            INS_RARE:   fill_val = rare_set;
            INS_HALF:   fill_val = phase_on;
            INS_THREAD: fill_val = cur_frag_q ? 1'b1 : rare_set;
            default:    fill_val = 1'b1;
        endcase
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (take_miss)        state_d = ST_SWEEP;
            ST_SWEEP: if (!rd_use[rd_hand]) state_d = ST_FILL;
            ST_FILL:                        state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    // outputs and state-array commands
    always_comb begin
        busy        = 1'b0;
        victim_done = 1'b0;
        victim_way  = rd_hand;
        wr_set      = cur_set_q;
        wr_en       = 1'b0;
        wr_way      = rd_hand;
        wr_val      = 1'b0;
        adv_en      = 1'b0;
        fill_step   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (take_hit) begin
                    wr_set = req_set;
                    wr_en  = 1'b1;
                    wr_way = req_way;
                    wr_val = 1'b1;
                end
            end
            ST_SWEEP: begin
                busy = 1'b1;
                if (rd_use[rd_hand]) begin
                    wr_en  = 1'b1;
                    wr_val = 1'b0;
                    adv_en = 1'b1;
                end
            end
            ST_FILL: begin
                busy        = 1'b1;
                victim_done = 1'b1;
                wr_en       = 1'b1;
                wr_val      = fill_val;
                fill_step   = 1'b1;
            end
            default: begin
                busy = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/rp_chk.sv
module rp_chk (
    input logic clk,
    input logic rst,
    input logic req_valid,
    input logic req_write,
    input logic req_hit,
    input logic busy,
    input logic victim_done
);
    // R3
    write_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_write && !busy) |=> (!busy && !victim_done));

    // R2
    hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && req_hit && !busy) |=> (!busy && !victim_done));

    // R4
    miss_start_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_write && !req_hit && !busy) |=> (busy && !victim_done));

    // R4
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        victim_done |=> (!victim_done && !busy));

    // R4
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        victim_done |-> busy);
endmodule

bind clock_repl rp_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_hit     (req_hit),
    .busy        (busy),
    .victim_done (victim_done)
);

// File: tb/sim_clock_repl.sv
module sim_clock_repl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic [3:0] req_set = '0;
    logic [3:0] req_way = '0;
    logic       req_hit = 1'b0;
    logic       req_write = 1'b0;
    logic [1:0] req_mode = '0;
    logic       req_fragile = 1'b0;
    logic       busy;
    logic       victim_done;
    logic [3:0] victim_way;

    int checks = 0;
    int errors = 0;
    int fills  = 0;
    bit m_use [16][16];
    int m_hand [16];

    always #5 clk = ~clk;

    clock_repl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_set(req_set),
        .req_way(req_way), .req_hit(req_hit), .req_write(req_write),
        .req_mode(req_mode), .req_fragile(req_fragile), .busy(busy),
        .victim_done(victim_done), .victim_way(victim_way)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int s = 0; s < 16; s++) begin
            m_hand[s] = 0;
            for (int w = 0; w < 16; w++) m_use[s][w] = 1'b0;
        end
        fills = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_clear();
    endtask

    // read miss; returns victim and cycles from request edge to strobe
    task automatic issue_miss(input int s, input int m, input bit fr,
                              output int way, output int lat);
        @(negedge clk);
        req_valid = 1'b1; req_set = 4'(s); req_hit = 1'b0; req_write = 1'b0;
        req_mode = 2'(m); req_fragile = fr;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        while (!victim_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        way = int'(victim_way);
        fills++;
    endtask

    task automatic issue_hit(input int s, input int w, input bit wr);
        @(negedge clk);
        req_valid = 1'b1; req_set = 4'(s); req_way = 4'(w); req_hit = 1'b1; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        if (!wr) m_use[s][w] = 1'b1;
    endtask

    // predicted miss from model; fill value known (-1 = unknown)
    task automatic checked_miss(input int s, input int m, input bit fr,
                                input int fv, input string tag);
        int h, k, way, lat;
        h = m_hand[s]; k = 0;
        while (m_use[s][h] && k < 16) begin
            m_use[s][h] = 1'b0;
            h = (h + 1) % 16;
            k++;
        end
        issue_miss(s, m, fr, way, lat);
        chk(way == h, {tag, " victim"}, way, h);
        chk(lat == 2 + k, {tag, " latency"}, lat, 2 + k);
        m_hand[s] = h;
        m_use[s][h] = (fv == 1);
    endtask

    task automatic t_reset();
        // R1
        chk(busy == 1'b0, "R1 busy after reset", busy, 0);
        chk(victim_done == 1'b0, "R1 done after reset", victim_done, 0);
        checked_miss(11, 0, 1'b0, 1, "R1 first miss");
    endtask

    task automatic t_normal();
        // R4 R5: hand stays on victim, normal fill marks it
        checked_miss(0, 0, 1'b0, 1, "R5 normal first");
        checked_miss(0, 0, 1'b0, 1, "R5 normal skip");
        checked_miss(0, 0, 1'b0, 1, "R4 normal third");
    endtask

    task automatic t_hit();
        // R2
        issue_hit(1, 0, 1'b0);
        chk(busy == 1'b0 && victim_done == 1'b0, "R2 hit quiet", busy, 0);
        checked_miss(1, 0, 1'b0, 1, "R2 hit marks way");
    endtask

    task automatic t_write();
        // R3: write hit and write miss leave set 2 unmarked
        issue_hit(2, 0, 1'b1);
        chk(busy == 1'b0 && victim_done == 1'b0, "R3 write hit quiet", busy, 0);
        @(negedge clk);
        req_valid = 1'b1; req_set = 4'd2; req_hit = 1'b0; req_write = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        chk(busy == 1'b0 && victim_done == 1'b0, "R3 write miss quiet", busy, 0);
        checked_miss(2, 0, 1'b0, 1, "R3 write ignored");
    endtask

    task automatic t_sweep();
        // R4: every way marked, sweep wraps to way 0 after 16 clears
        for (int w = 0; w < 16; w++) issue_hit(3, w, 1'b0);
        checked_miss(3, 0, 1'b0, 1, "R4 full sweep");
        checked_miss(3, 0, 1'b0, 1, "R4 after sweep");
    endtask

    task automatic t_busy();
        int lat;
        // R9: hit to set 7 presented during the first sweep cycle
        @(negedge clk);
        req_valid = 1'b1; req_set = 4'd4; req_hit = 1'b0; req_write = 1'b0; req_mode = 2'd0;
        @(negedge clk);
        chk(busy == 1'b1, "R9 busy during sweep", busy, 1);
        req_set = 4'd7; req_way = 4'd0; req_hit = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_hit = 1'b0;
        lat = 0;
        while (!victim_done && lat < 40) begin
            @(negedge clk);
            lat++;
        end
        fills++;
        m_use[4][0] = 1'b1;
        checked_miss(7, 0, 1'b0, 1, "R9 ignored hit");
    endtask

    task automatic t_half();
        // R7: fill count modulo 128 below 64 marks the victim
        for (int i = 0; i < 140; i++) begin
            checked_miss(5, 2, 1'b0, ((fills % 128) < 64) ? 1 : 0, "R7 half");
        end
    endtask

    task automatic t_fragile();
        // R8: fragile thread behaves as normal insertion
        checked_miss(8, 3, 1'b1, 1, "R8 fragile first");
        checked_miss(8, 3, 1'b1, 1, "R8 fragile skip");
    endtask

    task automatic count_changes(input int s, input int m, input int n, output int ch);
        int way, lat, prev;
        ch = 0; prev = -1;
        for (int i = 0; i < n; i++) begin
            issue_miss(s, m, 1'b0, way, lat);
            if (prev >= 0 && way != prev) ch++;
            prev = way;
        end
    endtask

    task automatic t_rare();
        int ch;
        // R6: victim moves only after a marked fill, about 1 in 32
        count_changes(9, 1, 256, ch);
        chk(ch >= 1 && ch <= 40, "R6 rare marking rate", ch, 8);
    endtask

    task automatic t_aggressive();
        int ch;
        // R8: aggressive thread behaves as rare insertion
        count_changes(10, 3, 256, ch);
        chk(ch >= 1 && ch <= 40, "R8 aggressive rate", ch, 8);
    endtask

    task automatic t_reset_mid();
        // R1: reset after marking; set 0 and set 3 return way 0 again
        do_reset();
        chk(busy == 1'b0 && victim_done == 1'b0, "R1 idle after reset", busy, 0);
        checked_miss(0, 0, 1'b0, 1, "R1 set0 cleared");
        checked_miss(3, 0, 1'b0, 1, "R1 set3 cleared");
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_normal();
        t_hit();
        t_write();
        t_sweep();
        t_busy();
        t_half();
        t_fragile();
        t_rare();
        t_aggressive();
        t_reset_mid();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule